// File: doc/BRIEF.md
# Shared Interrupt Line Router with System Control Interrupt Steering

The block takes eight level-sensitive shared-interrupt inputs and one system control interrupt (SCI) input. It drives them onto sixteen legacy interrupt-controller lines and onto a bank of advanced-controller global system interrupt (GSI) lines. Each shared input has a programmable route byte. The byte picks a legacy line, or it turns off legacy routing for that input. Several enabled inputs may pick the same legacy line, and that line is then the OR of all of them. On the advanced side every shared input owns one GSI line and shares it with nothing.

A control byte selects where the SCI lands. It can go to three legacy-range lines or to two lines in the advanced range. Some encodings leave it unrouted. A query port reports where any one input is currently delivered. A pulse flags every write that changes a route byte, so that software or a neighbouring block can refresh its own copy of the routing. All outputs are registered and follow the inputs with one cycle of latency.

Top module: `irq_line_router`

## Requirements
- R1: Reset does four things. Every route byte reads back 0x80. The control byte reads 0x00. All legacy and GSI outputs are low. The change pulse is low.
- R2: The register port has a fixed byte map. Route bytes for inputs 0..3 sit at addresses 0x0..0x3. Route bytes for inputs 4..7 sit at 0x8..0xB. The control byte is at 0x4. Writes land on the next clock edge, and reads are combinational. A write to any other address changes nothing, and such addresses read 0x00.
- R3: Each route byte has two fields. Bits [4:0] hold the legacy line number. Bit 7 set to 1 turns off legacy routing for that input. Bits 6:5 are stored but have no effect.
- R4: Legacy line k is high one cycle after this condition holds: any input is high whose route is enabled and selects k, or the SCI is high and is steered to k (k < 16).
- R5: An enabled route whose line number is 16 or more drives no legacy line.
- R6: GSI line 16+n follows input n one cycle later, whatever the state of its route byte.
- R7: The SCI target comes from control bits [2:0]. Encoding 0 selects line 9, 1 selects 10, 2 selects 11, 4 selects 20 and 5 selects 21. Encodings 3, 6 and 7 leave the SCI unrouted. Bits [7:3] have no effect.
- R8: A high SCI always raises the GSI line equal to its target. It also raises the legacy line of that number, but only when the target is below 16. GSI lines below 16 other than 9, 10 and 11 never go high.
- R9: A query of input n reports its delivery one cycle later, in three cases. If the route is enabled and its line is below 16, the result is routed=1 with that line. If the route is enabled and its line is 16 or more, the result is routed=0 with line 0. If the route is turned off, the result is routed=1 with line 16+n.
- R10: A write to any route byte address raises the change pulse for exactly one cycle, on the cycle after the write. A write to the control byte or to an unmapped address gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write byte address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read byte address |
| rd_data | output | 8 | Register read data (combinational) |
| pirq_i | input | 8 | Shared interrupt input levels |
| sci_i | input | 1 | System control interrupt level |
| qry_sel_i | input | 3 | Input index to query |
| legacy_o | output | 16 | Legacy controller lines |
| gsi_o | output | 24 | Advanced controller GSI lines |
| qry_routed_o | output | 1 | Query result: delivered |
| qry_line_o | output | 5 | Query result: line number |
| route_chg_o | output | 1 | One-cycle pulse after a route byte write |

## Verification
The assertions assume two things about the inputs. The interrupt levels and the SCI must be low while reset is held, because the first check after reset compares outputs with input values sampled during reset. Each input must also be stable between edges. The bench therefore holds every input at zero through reset and changes inputs only on falling edges. It then sweeps all 256 input patterns under several route tables, all eight control encodings with junk in the upper bits, and every legacy line number for every input.

// File: rtl/irq_line_router_pkg.sv
package irq_line_router_pkg;

    localparam int BYTE_W     = 8;
    localparam int IRQ_W      = 5;
    localparam int DIS_BIT    = 7;
    localparam int ENC_W      = 3;
    localparam int GRP_A_BASE = 0;
    localparam int GRP_B_BASE = 8;
    localparam int CTRL_ADDR  = 4;
    localparam logic [BYTE_W-1:0] ROUTE_RST = 8'h80;

    // SCI steering: returns -1 when the encoding leaves the SCI unrouted
    function automatic int sci_target(input logic [ENC_W-1:0] enc);
        case (enc)
            3'd0:    return 9;
            3'd1:    return 10;
            3'd2:    return 11;
            3'd4:    return 20;
            3'd5:    return 21;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/rtr_addr_dec.sv
module rtr_addr_dec
    import irq_line_router_pkg::*;
#(
    parameter int NUM_PIRQ = 8,
    parameter int ADDR_W   = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_PIRQ-1:0] route_hit,
    output logic                ctrl_hit
);
    localparam int GRP = NUM_PIRQ / 2;

    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_hit
        localparam int A = (n < GRP) ? (GRP_A_BASE + n) : (GRP_B_BASE + n - GRP);
        assign route_hit[n] = (addr == ADDR_W'(A));
    end

    assign ctrl_hit = (addr == ADDR_W'(CTRL_ADDR));
endmodule

// File: rtl/rtr_route_dec.sv
module rtr_route_dec
    import irq_line_router_pkg::*;
#(
    parameter int IDX      = 0,
    parameter int LEGACY_N = 16,
    parameter int LINE_W   = 5
) (
    input  logic [IRQ_W-1:0]    irq,
    input  logic                dis,
    output logic [LEGACY_N-1:0] leg_hit,
    output logic                q_ok,
    output logic [LINE_W-1:0]   q_line
);
    localparam logic [IRQ_W:0] LEG_LIM = (IRQ_W+1)'(LEGACY_N);
    localparam logic [LINE_W-1:0] OWN_GSI = LINE_W'(LEGACY_N + IDX);

    logic in_legacy;
    assign in_legacy = ({1'b0, irq} < LEG_LIM);

    for (genvar i = 0; i < LEGACY_N; i++) begin : g_leg
        assign leg_hit[i] = !dis && (irq == IRQ_W'(i));
    end

    always_comb begin
        if (dis) begin
            q_ok   = 1'b1;
            q_line = OWN_GSI;
        end else if (in_legacy) begin
            q_ok   = 1'b1;
            q_line = LINE_W'(irq);
        end else begin
            q_ok   = 1'b0;
            q_line = '0;
        end
    end
endmodule

// File: rtl/rtr_sci_dec.sv
module rtr_sci_dec
    import irq_line_router_pkg::*;
#(
    parameter int GSI_N  = 24,
    parameter int LINE_W = 5
) (
    input  logic [ENC_W-1:0]  enc,
    output logic              valid,
    output logic [LINE_W-1:0] line
);
    always_comb begin
        int t;
        t     = sci_target(enc);
        valid = (t >= 0) && (t < GSI_N);
        line  = valid ? LINE_W'(t) : '0;
    end
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
    import irq_line_router_pkg::*;
#(
    parameter int NUM_PIRQ = 8,
    parameter int LEGACY_N = 16,
    parameter int GSI_N    = 24,
    parameter int ADDR_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [BYTE_W-1:0]             rd_data,
    input  logic [NUM_PIRQ-1:0]           pirq_i,
    input  logic                          sci_i,
    input  logic [$clog2(NUM_PIRQ)-1:0]   qry_sel_i,
    output logic [LEGACY_N-1:0]           legacy_o,
    output logic [GSI_N-1:0]              gsi_o,
    output logic                          qry_routed_o,
    output logic [$clog2(GSI_N)-1:0]      qry_line_o,
    output logic                          route_chg_o
);
    localparam int LINE_W = $clog2(GSI_N);

    typedef struct packed {
        logic [NUM_PIRQ-1:0][BYTE_W-1:0] route;
        logic [BYTE_W-1:0]               ctrl;
        logic [LEGACY_N-1:0]             legacy;
        logic [GSI_N-1:0]                gsi;
        logic                            q_ok;
        logic [LINE_W-1:0]               q_line;
        logic                            chg;
    } state_t;

    state_t st_d, st_q;

    // Address decode for the write and read sides
    logic [NUM_PIRQ-1:0] wr_route_hit, rd_route_hit;
    logic                wr_ctrl_hit, rd_ctrl_hit;

    rtr_addr_dec #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_wdec (
        .addr(wr_addr), .route_hit(wr_route_hit), .ctrl_hit(wr_ctrl_hit)
    );
    rtr_addr_dec #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_rdec (
        .addr(rd_addr), .route_hit(rd_route_hit), .ctrl_hit(rd_ctrl_hit)
    );

    // Per-input route decode
    logic [NUM_PIRQ-1:0][LEGACY_N-1:0] leg_hit;
    logic [NUM_PIRQ-1:0]               q_ok;
    logic [NUM_PIRQ-1:0][LINE_W-1:0]   q_line;

    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_route
        rtr_route_dec #(.IDX(n), .LEGACY_N(LEGACY_N), .LINE_W(LINE_W)) u_dec (
            .irq    (st_q.route[n][IRQ_W-1:0]),
            .dis    (st_q.route[n][DIS_BIT]),
            .leg_hit(leg_hit[n]),
            .q_ok   (q_ok[n]),
            .q_line (q_line[n])
        );
    end

    // SCI steering
    logic              sci_ok;
    logic [LINE_W-1:0] sci_line;

    rtr_sci_dec #(.GSI_N(GSI_N), .LINE_W(LINE_W)) u_sci (
        .enc(st_q.ctrl[ENC_W-1:0]), .valid(sci_ok), .line(sci_line)
    );

    always_comb begin
        logic [LEGACY_N-1:0] leg_acc;
        logic [GSI_N-1:0]    gsi_acc;

        st_d     = st_q;
        st_d.chg = 1'b0;

        if (wr_en) begin
            for (int n = 0; n < NUM_PIRQ; n++) begin
                if (wr_route_hit[n]) st_d.route[n] = wr_data;
            end
            if (wr_ctrl_hit) st_d.ctrl = wr_data;
            st_d.chg = |wr_route_hit;
        end

        leg_acc = '0;
        for (int n = 0; n < NUM_PIRQ; n++) begin
            if (pirq_i[n]) leg_acc = leg_acc | leg_hit[n];
        end
        for (int i = 0; i < LEGACY_N; i++) begin
            if (sci_ok && sci_i && (sci_line == LINE_W'(i))) leg_acc[i] = 1'b1;
        end
        st_d.legacy = leg_acc;

        gsi_acc = '0;
        for (int n = 0; n < NUM_PIRQ; n++) begin
            gsi_acc[LEGACY_N + n] = pirq_i[n];
        end
        for (int g = 0; g < GSI_N; g++) begin
            if (sci_ok && sci_i && (sci_line == LINE_W'(g))) gsi_acc[g] = 1'b1;
        end
        st_d.gsi = gsi_acc;

        st_d.q_ok   = q_ok[qry_sel_i];
        st_d.q_line = q_line[qry_sel_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.route  <= {NUM_PIRQ{ROUTE_RST}};
            st_q.ctrl   <= '0;
            st_q.legacy <= '0;
            st_q.gsi    <= '0;
            st_q.q_ok   <= 1'b0;
            st_q.q_line <= '0;
            st_q.chg    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < NUM_PIRQ; n++) begin
            if (rd_route_hit[n]) rd_data = st_q.route[n];
        end
        if (rd_ctrl_hit) rd_data = st_q.ctrl;
    end

    assign legacy_o     = st_q.legacy;
    assign gsi_o        = st_q.gsi;
    assign qry_routed_o = st_q.q_ok;
    assign qry_line_o   = st_q.q_line;
    assign route_chg_o  = st_q.chg;
endmodule

// File: rtl/irq_line_router_chk.sv
module irq_line_router_chk
    import irq_line_router_pkg::*;
#(
    parameter int NUM_PIRQ = 8,
    parameter int LEGACY_N = 16,
    parameter int GSI_N    = 24
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [NUM_PIRQ-1:0]          pirq_i,
    input logic                         sci_i,
    input logic [LEGACY_N-1:0]          legacy_o,
    input logic [GSI_N-1:0]             gsi_o,
    input logic                         qry_routed_o,
    input logic [$clog2(GSI_N)-1:0]     qry_line_o,
    input logic                         route_chg_o
);
    localparam int LINE_W = $clog2(GSI_N);

    function automatic logic [LEGACY_N-1:0] low_sci_mask();
        logic [LEGACY_N-1:0] m;
        m = '0;
        for (int e = 0; e < 8; e++) begin
            int t;
            t = sci_target(ENC_W'(e));
            if (t >= 0 && t < LEGACY_N) m[t] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [LEGACY_N-1:0] LOW_MASK = low_sci_mask();
    localparam logic [LINE_W-1:0] GSI_TOP = LINE_W'(LEGACY_N + NUM_PIRQ - 1);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (legacy_o == '0 && gsi_o == '0 && !route_chg_o));

    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_gsi
        assert_gsi_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(pirq_i[n]) |-> gsi_o[LEGACY_N + n]);
    end

    assert_idle_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pirq_i) == '0 && !$past(sci_i)) |-> (legacy_o == '0 && gsi_o == '0));

    assert_low_gsi_only_sci_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gsi_o[LEGACY_N-1:0] & ~LOW_MASK) == '0);

    assert_low_gsi_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gsi_o[LEGACY_N-1:0]));

    assert_pulse_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> !route_chg_o);

    assert_query_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_routed_o && qry_line_o >= LINE_W'(LEGACY_N)) |-> (qry_line_o <= GSI_TOP));
endmodule

bind irq_line_router irq_line_router_chk #(
    .NUM_PIRQ(NUM_PIRQ), .LEGACY_N(LEGACY_N), .GSI_N(GSI_N)
) u_chk (.*);

// File: tb/sim_irq_line_router.sv
`timescale 1ns/1ps
module sim_irq_line_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [7:0]  pirq_i = '0;
    logic        sci_i = 1'b0;
    logic [2:0]  qry_sel_i = '0;
    logic [15:0] legacy_o;
    logic [23:0] gsi_o;
    logic        qry_routed_o;
    logic [4:0]  qry_line_o;
    logic        route_chg_o;

    int tests = 0;
    int fails = 0;
    logic [7:0] rt [8];
    logic [7:0] ctrl_m = '0;

    always #2.5 clk = ~clk;

    irq_line_router u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] addr_of(input int n);
        return (n < 4) ? 4'(n) : 4'(8 + n - 4);
    endfunction

    function automatic int sci_dest(input logic [7:0] c);
        case (c[2:0])
            3'd0: return 9;
            3'd1: return 10;
            3'd2: return 11;
            3'd4: return 20;
            3'd5: return 21;
            default: return -1;
        endcase
    endfunction

    function automatic logic [15:0] exp_leg();
        logic [15:0] e = '0;
        int t;
        for (int n = 0; n < 8; n++)
            if (pirq_i[n] && !rt[n][7] && rt[n][4:0] < 16) e[rt[n][3:0]] = 1'b1;
        t = sci_dest(ctrl_m);
        if (sci_i && t >= 0 && t < 16) e[t] = 1'b1;
        return e;
    endfunction

    function automatic logic [23:0] exp_gsi();
        logic [23:0] e = '0;
        int t;
        for (int n = 0; n < 8; n++) e[16+n] = pirq_i[n];
        t = sci_dest(ctrl_m);
        if (sci_i && t >= 0) e[t] = 1'b1;
        return e;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        for (int n = 0; n < 8; n++) if (a == addr_of(n)) return rt[n];
        if (a == 4'd4) return ctrl_m;
        return 8'h00;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_route(input int n, input logic [7:0] v);
        wr(addr_of(n), v);
        rt[n] = v;
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        wr(4'd4, v);
        ctrl_m = v;
    endtask

    task automatic apply(input logic [7:0] p, input logic s, input string req);
        @(negedge clk);
        pirq_i = p; sci_i = s;
        @(negedge clk);
        chk(req, 32'(legacy_o), 32'(exp_leg()));
        chk(req, 32'(gsi_o), 32'(exp_gsi()));
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a);
            #0.5;
            chk(req, 32'(rd_data), 32'(exp_rd(4'(a))));
        end
    endtask

    task automatic query(input int n);
        logic ok;
        logic [4:0] line;
        @(negedge clk);
        qry_sel_i = 3'(n);
        @(negedge clk);
        if (rt[n][7]) begin ok = 1'b1; line = 5'(16 + n); end
        else if (rt[n][4:0] < 16) begin ok = 1'b1; line = rt[n][4:0]; end
        else begin ok = 1'b0; line = 5'd0; end
        chk("R9 routed", 32'(qry_routed_o), 32'(ok));
        chk("R9 line", 32'(qry_line_o), 32'(line));
    endtask

    initial begin
        #(5.0 * 190000);
        fails++;
        tests++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int n = 0; n < 8; n++) rt[n] = 8'h80;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 legacy in reset", 32'(legacy_o), 0);
        chk("R1 gsi in reset", 32'(gsi_o), 0);
        chk("R1 pulse in reset", 32'(route_chg_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        read_all("R1 R2 reset readback");

        // R6 with all routes off: GSI follows, no legacy line (R3 disable bit)
        for (int p = 0; p < 256; p++) apply(8'(p), 1'b0, "R6 R3 gsi sweep");

        // R4: every input onto every legacy line, with junk in bits 6:5 (R3)
        for (int n = 0; n < 8; n++) begin
            for (int k = 0; k < 16; k++) begin
                set_route(n, 8'(k) | ((k % 3 == 0) ? 8'h60 : 8'h00));
                apply(8'(1 << n), 1'b0, "R4 R3 single route");
            end
            query(n);
            set_route(n, 8'h80);
        end

        // R5: line numbers 16..31 reach no legacy line; query says not delivered
        for (int k = 16; k < 32; k++) begin
            set_route(k % 8, 8'(k));
            apply(8'hFF, 1'b0, "R5 high line");
            query(k % 8);
            set_route(k % 8, 8'h80);
        end

        // R4 sharing table with mixed disabled and out-of-range routes
        set_route(0, 8'h05); set_route(1, 8'h05); set_route(2, 8'h85);
        set_route(3, 8'h0C); set_route(4, 8'h0C); set_route(5, 8'h14);
        set_route(6, 8'h09); set_route(7, 8'h83);
        read_all("R2 route readback");
        for (int n = 0; n < 8; n++) query(n);
        for (int p = 0; p < 256; p++) apply(8'(p), 1'b0, "R4 shared lines");

        // R7 R8: every encoding, upper bits junk, SCI alone then with inputs
        for (int e = 0; e < 8; e++) begin
            set_ctrl(8'(e) | ((e % 2 == 1) ? 8'hF8 : 8'h48));
            apply(8'h00, 1'b1, "R7 R8 sci alone");
            apply(8'h00, 1'b0, "R7 sci low");
            for (int p = 0; p < 256; p += 37) apply(8'(p), 1'b1, "R8 sci with inputs");
        end

        // R10 change pulse
        set_ctrl(8'h00);
        chk("R10 no pulse on control write", 32'(route_chg_o), 0);
        set_route(5, 8'h07);
        chk("R10 pulse after route write", 32'(route_chg_o), 1);
        @(negedge clk);
        chk("R10 pulse lasts one cycle", 32'(route_chg_o), 0);
        set_route(1, 8'h02);
        chk("R10 pulse for low group", 32'(route_chg_o), 1);
        wr(4'hF, 8'h3C);
        chk("R10 no pulse on unmapped write", 32'(route_chg_o), 0);
        wr(4'h6, 8'h11);
        read_all("R2 unmapped write ignored");
        apply(8'hFF, 1'b1, "R2 outputs after unmapped write");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule